// File: doc/BRIEF.md
# TDM Routing Table Entry Tracker

This block follows a time-division-multiplexed serial interface as it walks its routing table. It keeps a separate record for the receive side and for the transmit side. Each side reports its current entry as a pair of narrow pointers plus one bank bit. A host reads these registers as status.

There are two table layouts.

- **Split layout:** one 64-entry table is covered by two 5-bit pointers. The first pointer counts through entries 1 to 32 while the second stays at zero. For entries 33 to 64 the roles swap: the second pointer counts and the first stays at zero.
- **Banked layout:** the table is two 32-entry banks used in ping-pong fashion. Each entry is 2 bytes, so a bank spans 64 bytes. The bank bit selects which pointer carries the entry. The host asks for a bank change with a swap request, and the change takes effect at the next frame boundary.

A frame boundary is either a frame-start pulse or an advance strobe that arrives while the last-entry flag is raised. At a boundary the sequence returns to entry 1.

Top module: `tdm_ptr_tracker`

## Requirements
- R1: A synchronous active-high reset clears all four pointers and both bank bits on the next clock edge.
- R2: With mode not equal to 01 and the entry in 1..32, an advance moves the first pointer to (entry-1) and holds the second pointer at zero. An advance from entry 32 goes to entry 33.
- R3: With mode not equal to 01 and the entry in 33..64, the first pointer reads zero and the second reads (entry-33). An advance from entry 64 returns to entry 1.
- R4: Receive and transmit hold separate state. Strobes, flags, valid bits and swap requests of one side never change the other side's outputs.
- R5: When a side's valid bit is low, both of its pointers read zero on the next cycle and its advance strobes are ignored.
- R6: An advance strobe with the last-entry flag high returns that side to entry 1, with both pointers zero.
- R7: A frame-start pulse returns every valid side to entry 1 and takes priority over a simultaneous advance.
- R8: In mode 01, the entry (0-based) is reported in the first pointer when the bank bit is 0 and in the second pointer when it is 1. The other pointer reads zero. An advance from the 32nd entry of a bank wraps to the first entry of the same bank.
- R9: In mode 01, a valid side whose swap request is high at a frame boundary inverts its bank bit, and its pointers restart at zero. Bank 0 is the lower bank: receive bytes 0-63, transmit bytes 128-191. Bank 1 is the upper bank: receive bytes 64-127, transmit bytes 192-255.
- R10: In mode 01 the bank bit does not change without a boundary that coincides with a swap request. In any other mode the bank bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Layout select: 01 is banked; all other values are split |
| frame_start | input | 1 | Frame boundary pulse, shared by both sides |
| rx_valid | input | 1 | Receive pointer indication enable |
| rx_adv | input | 1 | Receive entry advance strobe |
| rx_last | input | 1 | Receive current entry is the last of the frame |
| rx_swap_req | input | 1 | Receive bank change request |
| tx_valid | input | 1 | Transmit pointer indication enable |
| tx_adv | input | 1 | Transmit entry advance strobe |
| tx_last | input | 1 | Transmit current entry is the last of the frame |
| tx_swap_req | input | 1 | Transmit bank change request |
| rx_ptr1 | output | 5 | Receive first pointer |
| rx_ptr2 | output | 5 | Receive second pointer |
| rx_bank | output | 1 | Receive bank bit |
| tx_ptr1 | output | 5 | Transmit first pointer |
| tx_ptr2 | output | 5 | Transmit second pointer |
| tx_bank | output | 1 | Transmit bank bit |

## Verification
The properties assume that the mode field changes only in a cycle that also carries a frame-start pulse. Under that assumption, a set bank bit always means the banked layout was in force when the pointers were last written. The bench respects this: it drives a frame start on every cycle where it changes mode. Swap requests are held high during ordinary advances, so the bench shows that a request alone, without a boundary, leaves the bank bit unchanged.

// File: rtl/tdm_ptr_pkg.sv
package tdm_ptr_pkg;

    typedef enum logic [1:0] {
        MODE_SPLIT  = 2'b00,
        MODE_BANKED = 2'b01,
        MODE_RSV2   = 2'b10,
        MODE_RSV3   = 2'b11
    } tdm_mode_e;

    localparam int unsigned NUM_DIRS = 2;
    localparam int unsigned DIR_RX   = 0;
    localparam int unsigned DIR_TX   = 1;

endpackage

// File: rtl/tdm_ptr_bank.sv
// Next value of one side's bank bit.
module tdm_ptr_bank (
    input  logic banked,
    input  logic valid,
    input  logic boundary,
    input  logic swap_req,
    input  logic bank_q,
    output logic bank_d
);
    always_comb begin
        if (!banked) begin
            bank_d = 1'b0;
        end else if (valid && boundary && swap_req) begin
            bank_d = ~bank_q;
        end else begin
            bank_d = bank_q;
        end
    end
endmodule

// File: rtl/tdm_ptr_dir.sv
// Pointer pair, half flag and bank bit for one direction.
module tdm_ptr_dir
    import tdm_ptr_pkg::*;
#(
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             frame_start,
    input  logic             valid,
    input  logic             adv,
    input  logic             last,
    input  logic             swap_req,
    output logic [PTR_W-1:0] ptr1,
    output logic [PTR_W-1:0] ptr2,
    output logic             bank
);
    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};
    localparam logic [PTR_W-1:0] PTR_ONE = {{(PTR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PTR_W-1:0] ptr1;
        logic [PTR_W-1:0] ptr2;
        logic             upper;
        logic             bank;
    } dir_state_t;

    dir_state_t s_d, s_q;
    logic       banked;
    logic       boundary;
    logic       bank_nxt;

    assign banked   = (tdm_mode_e'(mode) == MODE_BANKED);
    assign boundary = frame_start | (adv & last);

    tdm_ptr_bank u_bank (
        .banked   (banked),
        .valid    (valid),
        .boundary (boundary),
        .swap_req (swap_req),
        .bank_q   (s_q.bank),
        .bank_d   (bank_nxt)
    );

    always_comb begin
        s_d      = s_q;
        s_d.bank = bank_nxt;
        if (!valid || boundary) begin
            s_d.ptr1  = '0;
            s_d.ptr2  = '0;
            s_d.upper = 1'b0;
        end else if (adv) begin
            if (banked) begin
                s_d.upper = 1'b0;
                if (s_q.bank) begin
                    s_d.ptr1 = '0;
                    s_d.ptr2 = s_q.ptr2 + PTR_ONE;
                end else begin
                    s_d.ptr1 = s_q.ptr1 + PTR_ONE;
                    s_d.ptr2 = '0;
                end
            end else if (!s_q.upper) begin
                s_d.ptr2 = '0;
                if (s_q.ptr1 == PTR_MAX) begin
                    s_d.ptr1  = '0;
                    s_d.upper = 1'b1;
                end else begin
                    s_d.ptr1 = s_q.ptr1 + PTR_ONE;
                end
            end else begin
                s_d.ptr1 = '0;
                if (s_q.ptr2 == PTR_MAX) begin
                    s_d.ptr2  = '0;
                    s_d.upper = 1'b0;
                end else begin
                    s_d.ptr2 = s_q.ptr2 + PTR_ONE;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ptr1 = s_q.ptr1;
    assign ptr2 = s_q.ptr2;
    assign bank = s_q.bank;
endmodule

// File: rtl/tdm_ptr_tracker.sv
module tdm_ptr_tracker
    import tdm_ptr_pkg::*;
#(
    parameter int unsigned PTR_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic             frame_start,
    input  logic             rx_valid,
    input  logic             rx_adv,
    input  logic             rx_last,
    input  logic             rx_swap_req,
    input  logic             tx_valid,
    input  logic             tx_adv,
    input  logic             tx_last,
    input  logic             tx_swap_req,
    output logic [PTR_W-1:0] rx_ptr1,
    output logic [PTR_W-1:0] rx_ptr2,
    output logic             rx_bank,
    output logic [PTR_W-1:0] tx_ptr1,
    output logic [PTR_W-1:0] tx_ptr2,
    output logic             tx_bank
);
    logic [NUM_DIRS-1:0] vld_a, adv_a, last_a, swap_a, bank_a;
    logic [PTR_W-1:0]    p1_a [NUM_DIRS];
    logic [PTR_W-1:0]    p2_a [NUM_DIRS];

    assign vld_a  = {tx_valid,    rx_valid};
    assign adv_a  = {tx_adv,      rx_adv};
    assign last_a = {tx_last,     rx_last};
    assign swap_a = {tx_swap_req, rx_swap_req};

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_dir
        tdm_ptr_dir #(.PTR_W(PTR_W)) u_dir (
            .clk         (clk),
            .rst         (rst),
            .mode        (mode),
            .frame_start (frame_start),
            .valid       (vld_a[g]),
            .adv         (adv_a[g]),
            .last        (last_a[g]),
            .swap_req    (swap_a[g]),
            .ptr1        (p1_a[g]),
            .ptr2        (p2_a[g]),
            .bank        (bank_a[g])
        );
    end

    assign rx_ptr1 = p1_a[DIR_RX];
    assign rx_ptr2 = p2_a[DIR_RX];
    assign rx_bank = bank_a[DIR_RX];
    assign tx_ptr1 = p1_a[DIR_TX];
    assign tx_ptr2 = p2_a[DIR_TX];
    assign tx_bank = bank_a[DIR_TX];
endmodule

// File: rtl/tdm_ptr_chk.sv
module tdm_ptr_chk #(
    parameter int unsigned PTR_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       mode,
    input logic             frame_start,
    input logic             rx_valid,
    input logic             rx_adv,
    input logic             rx_last,
    input logic             tx_valid,
    input logic             tx_adv,
    input logic             tx_last,
    input logic [PTR_W-1:0] rx_ptr1,
    input logic [PTR_W-1:0] rx_ptr2,
    input logic             rx_bank,
    input logic [PTR_W-1:0] tx_ptr1,
    input logic [PTR_W-1:0] tx_ptr2,
    input logic             tx_bank
);
    localparam logic [PTR_W-1:0] PMAX = {PTR_W{1'b1}};
    localparam logic [PTR_W-1:0] PONE = {{(PTR_W-1){1'b0}}, 1'b1};

    assert_pair_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
        !((rx_ptr1 != '0) && (rx_ptr2 != '0)) && !((tx_ptr1 != '0) && (tx_ptr2 != '0)));

    assert_lower_step_R2: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b01 && rx_valid && rx_adv && !rx_last && !frame_start
         && rx_ptr1 != '0 && rx_ptr1 != PMAX)
        |=> (rx_ptr1 == $past(rx_ptr1) + PONE) && (rx_ptr2 == '0));

    assert_upper_step_R3: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b01 && rx_valid && rx_adv && !rx_last && !frame_start
         && rx_ptr2 != '0 && rx_ptr2 != PMAX)
        |=> (rx_ptr2 == $past(rx_ptr2) + PONE) && (rx_ptr1 == '0));

    assert_invalid_clears_R5: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> (rx_ptr1 == '0) && (rx_ptr2 == '0));

    assert_invalid_clears_tx_R5: assert property (@(posedge clk) disable iff (rst)
        !tx_valid |=> (tx_ptr1 == '0) && (tx_ptr2 == '0));

    assert_last_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_adv && rx_last) |=> (rx_ptr1 == '0) && (rx_ptr2 == '0));

    assert_frame_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && frame_start) |=> (tx_ptr1 == '0) && (tx_ptr2 == '0));

    assert_banked_side_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && rx_bank) |-> (rx_ptr1 == '0));

    assert_bank_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'b01) |=> (!rx_bank && !tx_bank));

    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b01 && !frame_start && !(tx_adv && tx_last)) |=> $stable(tx_bank));
endmodule

bind tdm_ptr_tracker tdm_ptr_chk #(.PTR_W(PTR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mode        (mode),
    .frame_start (frame_start),
    .rx_valid    (rx_valid),
    .rx_adv      (rx_adv),
    .rx_last     (rx_last),
    .tx_valid    (tx_valid),
    .tx_adv      (tx_adv),
    .tx_last     (tx_last),
    .rx_ptr1     (rx_ptr1),
    .rx_ptr2     (rx_ptr2),
    .rx_bank     (rx_bank),
    .tx_ptr1     (tx_ptr1),
    .tx_ptr2     (tx_ptr2),
    .tx_bank     (tx_bank)
);

// File: tb/tdm_ptr_tracker_tb.sv
`timescale 1ns/1ps
module tdm_ptr_tracker_tb;
    localparam int PW = 5;
    localparam int HALF = 1 << PW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic frame_start = 1'b0;
    logic rx_valid = 1'b0, rx_adv = 1'b0, rx_last = 1'b0, rx_swap_req = 1'b0;
    logic tx_valid = 1'b0, tx_adv = 1'b0, tx_last = 1'b0, tx_swap_req = 1'b0;
    logic [PW-1:0] rx_ptr1, rx_ptr2, tx_ptr1, tx_ptr2;
    logic rx_bank, tx_bank;

    always #5 clk = ~clk;

    tdm_ptr_tracker #(.PTR_W(PW)) u_dut (
        .clk(clk), .rst(rst), .mode(mode), .frame_start(frame_start),
        .rx_valid(rx_valid), .rx_adv(rx_adv), .rx_last(rx_last), .rx_swap_req(rx_swap_req),
        .tx_valid(tx_valid), .tx_adv(tx_adv), .tx_last(tx_last), .tx_swap_req(tx_swap_req),
        .rx_ptr1(rx_ptr1), .rx_ptr2(rx_ptr2), .rx_bank(rx_bank),
        .tx_ptr1(tx_ptr1), .tx_ptr2(tx_ptr2), .tx_bank(tx_bank)
    );

    typedef logic [4*PW+1:0] obs_t;
    obs_t  expq [$];
    string tagq [$];
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference state: 0-based entry index and bank per side
    int rx_e = 0, tx_e = 0;
    bit rx_b = 0, tx_b = 0;

    function automatic void ref_step(input bit r, input logic [1:0] m, input bit fs,
                                     input bit v, input bit a, input bit l, input bit s,
                                     inout int e, inout bit b);
        if (r) begin
            e = 0; b = 0;
        end else begin
            if (!v) e = 0;
            else if (fs || (a && l)) begin
                e = 0;
                if (m == 2'b01 && s) b = !b;
            end else if (a) e = (m == 2'b01) ? (e + 1) % HALF : (e + 1) % (2 * HALF);
            if (m != 2'b01) b = 0;
        end
    endfunction

    function automatic logic [2*PW:0] ref_view(input logic [1:0] m, input int e, input bit b);
        logic [PW-1:0] p1, p2;
        if (m == 2'b01) begin
            p1 = b ? '0 : PW'(e);
            p2 = b ? PW'(e) : '0;
        end else begin
            p1 = (e < HALF) ? PW'(e) : '0;
            p2 = (e < HALF) ? '0 : PW'(e - HALF);
        end
        return {p1, p2, b};
    endfunction

    // driver: one cycle of stimulus, expected result pushed to the scoreboard
    task automatic cyc(input bit r, input logic [1:0] m, input bit fs,
                       input bit rv, input bit ra, input bit rl, input bit rs,
                       input bit tv, input bit ta, input bit tl, input bit ts,
                       input string tag);
        @(negedge clk);
        rst = r; mode = m; frame_start = fs;
        rx_valid = rv; rx_adv = ra; rx_last = rl; rx_swap_req = rs;
        tx_valid = tv; tx_adv = ta; tx_last = tl; tx_swap_req = ts;
        ref_step(r, m, fs, rv, ra, rl, rs, rx_e, rx_b);
        ref_step(r, m, fs, tv, ta, tl, ts, tx_e, tx_b);
        expq.push_back({ref_view(m, rx_e, rx_b), ref_view(m, tx_e, tx_b)});
        tagq.push_back(tag);
    endtask

    // monitor: compares just after each rising edge
    always @(posedge clk) begin
        #1;
        if (expq.size() > 0) begin
            obs_t exp_v, act_v;
            string t;
            exp_v = expq.pop_front();
            t = tagq.pop_front();
            act_v = {rx_ptr1, rx_ptr2, rx_bank, tx_ptr1, tx_ptr2, tx_bank};
            checks++;
            if (act_v !== exp_v) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", t, act_v, exp_v);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        cyc(1, 2'b00, 0, 0,0,0,0, 0,0,0,0, "R1 reset");
        cyc(1, 2'b00, 0, 1,1,0,0, 1,1,0,0, "R1 reset");
        cyc(0, 2'b00, 1, 1,0,0,0, 1,0,0,0, "R7 start");
        // split layout: rx every cycle, tx every other cycle
        for (int i = 0; i < 70; i++)
            cyc(0, 2'b00, 0, 1,1,0,0, 1,i[0],0,0, "R2 R3 R4 split walk");
        // rx disabled, strobes ignored, tx keeps going
        for (int i = 0; i < 4; i++)
            cyc(0, 2'b00, 0, 0,1,0,0, 1,1,0,0, "R5 R4 invalid");
        for (int i = 0; i < 5; i++)
            cyc(0, 2'b00, 0, 1,1,0,0, 1,0,0,0, "R2 resume");
        cyc(0, 2'b00, 0, 1,1,1,0, 1,0,0,0, "R6 last wrap");
        cyc(0, 2'b00, 0, 1,1,0,0, 1,1,0,0, "R6 after wrap");
        for (int i = 0; i < 3; i++)
            cyc(0, 2'b00, 0, 1,1,0,0, 1,1,0,0, "R2 walk");
        cyc(0, 2'b00, 1, 1,1,0,0, 1,1,0,0, "R7 start beats advance");
        // banked layout: rx swaps at start, tx does not
        cyc(0, 2'b01, 1, 1,0,0,1, 1,0,0,0, "R9 R4 swap at start");
        for (int i = 0; i < 35; i++)
            cyc(0, 2'b01, 0, 1,1,0,1, 1,1,0,1, "R8 R10 banked walk, requests held");
        cyc(0, 2'b01, 0, 1,1,0,0, 1,1,1,1, "R9 tx swap on last");
        for (int i = 0; i < 3; i++)
            cyc(0, 2'b01, 0, 1,1,0,0, 1,1,0,0, "R8 walk");
        cyc(0, 2'b01, 0, 0,0,0,1, 1,0,0,0, "R10 R5 no boundary");
        cyc(0, 2'b01, 1, 0,0,0,1, 1,0,0,0, "R9 invalid side keeps bank");
        cyc(0, 2'b01, 1, 1,0,0,1, 1,0,0,1, "R9 both swap");
        for (int i = 0; i < 3; i++)
            cyc(0, 2'b01, 0, 1,1,0,0, 1,1,0,0, "R8 walk");
        cyc(0, 2'b00, 1, 1,0,0,0, 1,0,0,0, "R10 split forces bank 0");
        cyc(0, 2'b10, 1, 1,0,0,1, 1,0,0,1, "R10 reserved mode no swap");
        for (int i = 0; i < 3; i++)
            cyc(0, 2'b10, 0, 1,1,0,0, 1,1,0,0, "R2 reserved mode as split");
        cyc(1, 2'b10, 0, 1,1,0,0, 1,1,0,0, "R1 reset again");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule